// File: doc/BRIEF.md
# Decimal-Adjust Accumulator and Flag Unit

This block is the 8-bit accumulator datapath of a small processor. It does binary add and subtract, with and without carry, the bitwise AND, OR and XOR, and two carry-only operations. Around these sits a packed-decimal correction step that runs over two clock cycles. From the operands and the incoming flag word it computes the next accumulator value and the next five flags. It presents both on registered outputs, together with a one-cycle valid strobe.

A sequencer pulses `start_i` with the opcode, the two operands and the current flags. Every operation except decimal adjust answers in the next cycle. Decimal adjust puts its correction sum in a register first and answers one cycle after that. The unit ignores a start that arrives while an adjust is still in flight. Between strobes the outputs keep their last values.

Top module: `acc_flag_unit`

## Requirements
- R1: The flag word is 5 bits: bit 4 sign, bit 3 zero, bit 2 aux-carry, bit 1 parity, bit 0 carry. Every accepted start whose opcode is not 7 gives `valid_o` high for exactly the next cycle, with `result_o` and `flags_o` loaded.
- R2: Opcode 0 (add) gives opa+opb. Opcode 1 (add with carry) gives opa+opb+carry. In both, carry is bit 8 of the sum.
- R3: Opcode 2 (subtract) gives opa-opb. Opcode 3 (subtract with borrow) gives opa-opb-carry. In both, carry is set exactly when a borrow occurs.
- R4: For opcodes 0 to 3, aux-carry is bit 4 of (opa XOR b' XOR result), where b' is opb for add and ~opb for subtract.
- R5: Except for opcodes 8 and 9 and undefined codes, sign is result bit 7, zero is 1 when the result is 00h, and parity is 1 when the result has an even number of ones.
- R6: Opcode 4 (AND) clears carry and sets aux-carry to opa[3] OR opb[3]. Opcodes 5 (XOR) and 6 (OR) clear both carry and aux-carry.
- R7: Opcode 7 (decimal adjust, on opa) adds 06h when the low nibble is above 9 or aux-carry is 1. It adds 60h when the high nibble is above 9, or carry is 1, or the high nibble is 9 and the low nibble is above 9. Both choices come from the original value and are added as one addend, modulo 256.
- R8: After decimal adjust, aux-carry equals (original low nibble above 9). Carry equals (incoming carry OR original low nibble above 9).
- R9: Decimal adjust raises `valid_o` two cycles after start, and `valid_o` stays low in the cycle between. A start during that in-between cycle is ignored and gives no strobe.
- R10: Opcode 8 forces carry to 1 and opcode 9 inverts it. Both pass opa to the result and leave the other four flags as they came in.
- R11: Reset clears result, flags and valid. While `valid_o` is low the outputs hold. Undefined opcodes (10 to 15) return opa with the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation this cycle |
| op_i | input | 4 | Operation code |
| opa_i | input | 8 | Accumulator operand |
| opb_i | input | 8 | Second operand |
| flags_i | input | 5 | Current flag word |
| result_o | output | 8 | Registered result |
| flags_o | output | 5 | Registered next flag word |
| valid_o | output | 1 | One-cycle strobe for a new result |

## Verification
The adder is driven with small operands, with sums that wrap past FFh and with carry-in set. These separate a correct carry out of bit 8 from a correct nibble carry out of bit 3. Subtract cases borrow and do not borrow, so an inverted borrow sense is caught. Decimal adjust is tried on each rule path: low-only correction caused by aux-carry, high-only correction caused by carry, the case with high nibble 9 and low nibble above 9, and a high nibble above 9 that wraps to zero. This last case shows that carry follows only the low-nibble rule. A start placed during the adjust gap checks that the two-cycle path cannot be overrun.

// File: rtl/acc_flag_pkg.sv
package acc_flag_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBB = 4'd3,
    OP_AND = 4'd4,
    OP_XOR = 4'd5,
    OP_OR  = 4'd6,
    OP_DAA = 4'd7,
    OP_STC = 4'd8,
    OP_CMC = 4'd9
  } alu_op_e;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } flags_t;
endpackage

// File: rtl/acc_arith_core.sv
module acc_arith_core
  import acc_flag_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e         op_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  input  logic            cy_i,
  output logic [DW-1:0]   res_o,
  output logic            cy_o,
  output logic            ac_o
);
  localparam int NIB = DW / 2;

  logic          is_sub;
  logic          cin;
  logic [DW-1:0] b_eff;
  logic [DW:0]   sum;

  always_comb begin
    is_sub = (op_i == OP_SUB) || (op_i == OP_SBB);
    b_eff  = is_sub ? ~b_i : b_i;
    unique case (op_i)
      OP_ADC:  cin = cy_i;
      OP_SUB:  cin = 1'b1;
      OP_SBB:  cin = ~cy_i;
      default: cin = 1'b0;
    endcase
    sum = {1'b0, a_i} + {1'b0, b_eff} + {{DW{1'b0}}, cin};
  end

  always_comb begin
    res_o = a_i;
    cy_o  = cy_i;
    ac_o  = 1'b0;
    unique case (op_i)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
        res_o = sum[DW-1:0];
        cy_o  = is_sub ? ~sum[DW] : sum[DW];
        ac_o  = a_i[NIB] ^ b_eff[NIB] ^ sum[NIB];
      end
      OP_AND: begin
        res_o = a_i & b_i;
        cy_o  = 1'b0;
        ac_o  = a_i[NIB-1] | b_i[NIB-1];
      end
      OP_XOR: begin
        res_o = a_i ^ b_i;
        cy_o  = 1'b0;
      end
      OP_OR: begin
        res_o = a_i | b_i;
        cy_o  = 1'b0;
      end
      default: ;
    endcase
  end

  always_comb begin
    if (op_i == OP_XOR || op_i == OP_OR)
      AST_LOGIC_AC_CLR: assert (!ac_o && !cy_o); // R6
  end
endmodule

// File: rtl/acc_daa_stage.sv
module acc_daa_stage #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] acc_i,
  input  logic          ac_i,
  input  logic          cy_i,
  output logic [DW-1:0] sum_o,
  output logic          ac_o,
  output logic          cy_o
);
  localparam int NIB = DW / 2;
  localparam logic [NIB-1:0] NINE = NIB'(9);
  localparam logic [NIB-1:0] SIX  = NIB'(6);

  logic [NIB-1:0] lo_nib, hi_nib;
  logic           lo_big, hi_big, fix_lo, fix_hi;
  logic [DW-1:0]  addend;

  always_comb begin
    lo_nib = acc_i[NIB-1:0];
    hi_nib = acc_i[DW-1:NIB];
    lo_big = lo_nib > NINE;
    hi_big = hi_nib > NINE;
    fix_lo = lo_big | ac_i;
    fix_hi = hi_big | cy_i | ((hi_nib == NINE) & lo_big);
    addend = {(fix_hi ? SIX : {NIB{1'b0}}), (fix_lo ? SIX : {NIB{1'b0}})};
  end

  // adjust adder registered to keep it off the single-cycle path
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_o <= '0;
      ac_o  <= 1'b0;
      cy_o  <= 1'b0;
    end else if (load_i) begin
      sum_o <= acc_i + addend;
      ac_o  <= lo_big;
      cy_o  <= cy_i | lo_big;
    end
  end

  AST_DAA_CY_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && cy_i |=> cy_o); // R8
  AST_DAA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(sum_o)); // R7
endmodule

// File: rtl/acc_flag_gen.sv
module acc_flag_gen #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] res_i,
  output logic          s_o,
  output logic          z_o,
  output logic          p_o
);
  always_comb begin
    s_o = res_i[DW-1];
    z_o = (res_i == '0);
    p_o = ~^res_i;
  end
endmodule

// File: rtl/acc_flag_unit.sv
module acc_flag_unit
  import acc_flag_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] opa_i,
  input  logic [DW-1:0] opb_i,
  input  logic [4:0]    flags_i,
  output logic [DW-1:0] result_o,
  output logic [4:0]    flags_o,
  output logic          valid_o
);
  alu_op_e       op;
  flags_t        f_in, f_nxt, f_q;
  logic          accept, daa_go, carry_only, arith_known;
  logic          daa_pend_q, valid_q;
  logic [DW-1:0] ar_res, daa_sum, res_nxt, res_q;
  logic          ar_cy, ar_ac, daa_ac, daa_cy;
  logic          s_w, z_w, p_w;

  always_comb begin
    op          = alu_op_e'(op_i);
    f_in        = flags_t'(flags_i);
    accept      = start_i & ~daa_pend_q;
    daa_go      = accept & (op == OP_DAA);
    carry_only  = (op == OP_STC) || (op == OP_CMC);
    arith_known = (op_i <= 4'd6);
  end

  acc_arith_core #(.DW(DW)) u_arith (
    .op_i  (op),
    .a_i   (opa_i),
    .b_i   (opb_i),
    .cy_i  (f_in.cy),
    .res_o (ar_res),
    .cy_o  (ar_cy),
    .ac_o  (ar_ac)
  );

  acc_daa_stage #(.DW(DW)) u_daa (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (daa_go),
    .acc_i  (opa_i),
    .ac_i   (f_in.ac),
    .cy_i   (f_in.cy),
    .sum_o  (daa_sum),
    .ac_o   (daa_ac),
    .cy_o   (daa_cy)
  );

  assign res_nxt = daa_pend_q ? daa_sum : ar_res;

  acc_flag_gen #(.DW(DW)) u_flags (
    .res_i (res_nxt),
    .s_o   (s_w),
    .z_o   (z_w),
    .p_o   (p_w)
  );

  always_comb begin
    f_nxt = f_in;
    if (daa_pend_q) begin
      f_nxt = '{s: s_w, z: z_w, ac: daa_ac, p: p_w, cy: daa_cy};
    end else if (carry_only) begin
      f_nxt.cy = (op == OP_STC) ? 1'b1 : ~f_in.cy;
    end else if (arith_known) begin
      f_nxt = '{s: s_w, z: z_w, ac: ar_ac, p: p_w, cy: ar_cy};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      daa_pend_q <= 1'b0;
      valid_q    <= 1'b0;
      res_q      <= '0;
      f_q        <= '0;
    end else begin
      daa_pend_q <= daa_go;
      valid_q    <= daa_pend_q | (accept & ~daa_go);
      if (daa_pend_q || (accept && !daa_go)) begin
        res_q <= res_nxt;
        f_q   <= f_nxt;
      end
    end
  end

  assign result_o = res_q;
  assign flags_o  = f_q;
  assign valid_o  = valid_q;

  AST_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !daa_pend_q && op_i != 4'd7 |=> valid_o); // R1
  AST_DAA_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !daa_pend_q && op_i == 4'd7 |=> !valid_o && daa_pend_q); // R9
  AST_DAA_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    daa_pend_q |=> valid_o && !daa_pend_q); // R9
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(result_o) && $stable(flags_o)); // R11
  AST_STC_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !daa_pend_q && op_i == 4'd8 |=>
      flags_o[0] && flags_o[4:1] == $past(flags_i[4:1])); // R10
  AST_CMC_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !daa_pend_q && op_i == 4'd9 |=> flags_o[0] == !$past(flags_i[0])); // R10
  AST_LOGIC_NO_CY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !daa_pend_q && (op_i == 4'd4 || op_i == 4'd5 || op_i == 4'd6)
      |=> !flags_o[0]); // R6
endmodule

// File: tb/acc_flag_unit_tb.sv
module acc_flag_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] op = '0;
  logic [7:0] opa = '0, opb = '0;
  logic [4:0] flg = '0;
  logic [7:0] res;
  logic [4:0] fout;
  logic       vld;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  acc_flag_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .opa_i(opa), .opb_i(opb), .flags_i(flg),
    .result_o(res), .flags_o(fout), .valid_o(vld)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // independent reference: returns {result, flags}
  function automatic logic [12:0] model(input logic [3:0] o, input logic [7:0] a,
                                        input logic [7:0] b, input logic [4:0] f);
    int r, d, lo, hi, adj;
    logic c, h;
    logic [7:0] r8;
    c = 1'b0; h = 1'b0; r = 0;
    case (o)
      4'd0: begin r = a + b; c = r > 255; h = ((a ^ b ^ r) >> 4) & 1; end
      4'd1: begin r = a + b + f[0]; c = r > 255; h = ((a ^ b ^ r) >> 4) & 1; end
      4'd2, 4'd3: begin
        d = int'(a) - int'(b) - ((o == 4'd3) ? int'(f[0]) : 0);
        c = d < 0; r = d & 255;
        h = ((a ^ (~b & 8'hFF) ^ r) >> 4) & 1;
      end
      4'd4: begin r = a & b; h = a[3] | b[3]; end
      4'd5: r = a ^ b;
      4'd6: r = a | b;
      4'd7: begin
        lo = a % 16; hi = a / 16; adj = 0;
        if (lo > 9 || f[2]) adj += 6;
        if (hi > 9 || f[0] || (hi == 9 && lo > 9)) adj += 96;
        r = (a + adj) & 255; h = lo > 9; c = f[0] || lo > 9;
      end
      4'd8: return {a, f[4:1], 1'b1};
      4'd9: return {a, f[4:1], ~f[0]};
      default: return {a, f};
    endcase
    r8 = r[7:0];
    return {r8, r8[7], r8 == 8'h00, h, ~^r8, c};
  endfunction

  task automatic drive(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                       input logic [4:0] f);
    @(negedge clk);
    op = o; opa = a; opb = b; flg = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run(input string tag, input logic [3:0] o, input logic [7:0] a,
                     input logic [7:0] b, input logic [4:0] f);
    logic [12:0] e;
    e = model(o, a, b, f);
    drive(o, a, b, f);
    if (o == 4'd7) begin
      chk({tag, " gap"}, 32'(vld), 32'd0);
      @(negedge clk);
    end
    chk({tag, " valid"}, 32'(vld), 32'd1);
    chk({tag, " result"}, 32'(res), 32'(e[12:5]));
    chk({tag, " flags"}, 32'(fout), 32'(e[4:0]));
  endtask

  task automatic t_reset();
    chk("R11 reset valid", 32'(vld), 32'd0);
    chk("R11 reset result", 32'(res), 32'd0);
    chk("R11 reset flags", 32'(fout), 32'd0);
  endtask

  task automatic t_add();
    run("R2 add small", 4'd0, 8'h12, 8'h34, 5'b00000);
    run("R2 add wrap", 4'd0, 8'hF0, 8'h10, 5'b00000);
    run("R4 add nibble", 4'd0, 8'h0F, 8'h01, 5'b00000);
    run("R2 adc cin", 4'd1, 8'hFF, 8'h00, 5'b00001);
    run("R5 add parity odd", 4'd0, 8'h01, 8'h00, 5'b00000);
  endtask

  task automatic t_sub();
    run("R3 sub noborrow", 4'd2, 8'h50, 8'h20, 5'b00000);
    run("R3 sub borrow", 4'd2, 8'h20, 8'h50, 5'b00000);
    run("R4 sub nibble", 4'd2, 8'h10, 8'h01, 5'b00000);
    run("R3 sbb cin", 4'd3, 8'h05, 8'h05, 5'b00001);
    run("R5 sub zero", 4'd2, 8'h77, 8'h77, 5'b00001);
  endtask

  task automatic t_logic();
    run("R6 and ac", 4'd4, 8'h08, 8'hF0, 5'b00101);
    run("R6 and noac", 4'd4, 8'hF7, 8'hF7, 5'b00101);
    run("R6 xor", 4'd5, 8'hAA, 8'h0F, 5'b00101);
    run("R6 or", 4'd6, 8'h80, 8'h01, 5'b00101);
  endtask

  task automatic t_daa();
    run("R7 daa lo by ac", 4'd7, 8'h15, 8'h00, 5'b00100);
    run("R7 daa hi by cy", 4'd7, 8'h42, 8'h00, 5'b00001);
    run("R8 daa nine-big", 4'd7, 8'h9B, 8'h00, 5'b00000);
    run("R8 daa hi wrap", 4'd7, 8'hA0, 8'h00, 5'b00000);
    run("R7 daa none", 4'd7, 8'h38, 8'h00, 5'b00000);
  endtask

  task automatic t_carry_ops();
    run("R10 stc", 4'd8, 8'h3C, 8'h00, 5'b10110);
    run("R10 cmc set", 4'd9, 8'h3C, 8'h00, 5'b01010);
    run("R10 cmc clr", 4'd9, 8'h00, 8'h00, 5'b01011);
  endtask

  task automatic t_daa_busy();
    logic [12:0] e;
    e = model(4'd7, 8'h9B, 8'h00, 5'b00000);
    @(negedge clk);
    op = 4'd7; opa = 8'h9B; opb = 8'h00; flg = 5'b00000; start = 1'b1;
    @(negedge clk);
    op = 4'd0; opa = 8'h01; opb = 8'h01;
    chk("R9 busy gap", 32'(vld), 32'd0);
    @(negedge clk);
    start = 1'b0;
    chk("R9 busy valid", 32'(vld), 32'd1);
    chk("R9 busy result", 32'(res), 32'(e[12:5]));
    @(negedge clk);
    chk("R9 ignored start no strobe", 32'(vld), 32'd0);
    chk("R9 ignored start result", 32'(res), 32'(e[12:5]));
  endtask

  task automatic t_misc();
    run("R11 undefined op", 4'd12, 8'h5A, 8'h11, 5'b10101);
    @(negedge clk);
    chk("R11 hold result", 32'(res), 32'h5A);
    chk("R1 strobe one cycle", 32'(vld), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_add();
    t_sub();
    t_logic();
    t_daa();
    t_carry_ops();
    t_daa_busy();
    t_misc();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule